// File: doc/BRIEF.md
# Configuration Base Address Register Bank

This block holds the six base address registers of one PCI function as software sees them in configuration space. Each 32-bit register claims a window of address space whose size is a power of two, fixed per register by a parameter, together with its space type (memory or I/O) and, for memory, a prefetchable flag. A register stores only the address bits above its window size, so any base it holds is aligned to that size.

Software sizes a window by writing all ones and reading the word back: the low address bits come back as zeros and the count of those zeros gives the size. It then writes the real base. The block does not treat the all-ones write as special; every write passes through the same masking rule. A register whose size parameter is zero is absent. It reads as zero and claims nothing.

Alongside the configuration port the block compares an incoming bus address, tagged as memory or I/O, against every present window. It raises one hit bit per register when that space's decode enable is on and the address bits above the window size match the stored base.

Top module: `bar_bank`

## Requirements
- R1: After reset every stored base bit is zero, so each present register reads back only its four type bits.
- R2: A write to register i updates only the byte lanes whose enable is 1 (lane k is data bits 8k+7:8k), and within those lanes keeps only the bits at or above the window size. Lanes whose enable is 0 keep their value.
- R3: A read returns the stored upper bits with every bit below the window size forced to zero. After an all-ones write it therefore returns ones only above the window size, apart from the type bits.
- R4: For a memory window, read bit 0 is 0, bits 2:1 are 00 and bit 3 equals the prefetchable parameter. Writes cannot change these bits.
- R5: For an I/O window, read bit 0 is 1 and bits 3:1 are 000. Writes cannot change these bits.
- R6: A register whose size parameter is zero reads as 0x00000000 whatever is written, and its hit bit stays 0.
- R7: A write to an index of 6 or more changes no register, and a read at such an index returns zero.
- R8: A memory window's hit bit is 1 exactly when the memory decode enable is 1, the bus cycle is a memory cycle, and the bus address bits at or above the window size equal the stored base bits.
- R9: An I/O window's hit bit is 1 exactly when the I/O decode enable is 1, the bus cycle is an I/O cycle, and the address bits at or above the window size match the stored base.
- R10: Read data and hit bits are combinational in the current inputs and stored state. A written value becomes visible after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe for one cycle |
| cfg_idx | input | 3 | Register index for read and write |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the register at cfg_idx |
| mem_en | input | 1 | Memory space decode enable |
| io_en | input | 1 | I/O space decode enable |
| bus_addr | input | 32 | Address of the current bus cycle |
| bus_is_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| bar_hit | output | 6 | Per-register window hit, bit i for register i |

## Verification
Reads and hits take zero cycles: the bench sets the index or bus address at a falling edge and samples one time step later, with no clock edge in between. A write is driven at a falling edge and takes effect at the next rising edge, so the bench reads it back at the falling edge after that. For R10 it samples the hit output once before that rising edge to show the old base still decodes, and once after it to show the new base does. The vector table carries register state from row to row, so each expected word follows from the masking and byte-lane rules applied to the previous rows.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned TYPE_W = 4;

  // Bits kept by a window of 2**lg bytes; zero means the register is absent.
  function automatic logic [WORD_W-1:0] keep_mask(input int unsigned lg);
    logic [WORD_W-1:0] m;
    if (lg < TYPE_W || lg >= WORD_W) begin
      m = '0;
    end else begin
      m = ~((WORD_W'(1) << lg) - WORD_W'(1));
    end
    return m;
  endfunction

  // Read-only low nibble: space indicator, decoder type, prefetch flag.
  function automatic logic [TYPE_W-1:0] type_bits(input logic is_io,
                                                  input logic pref);
    logic [TYPE_W-1:0] t;
    if (is_io) begin
      t = 4'b0001;
    end else begin
      t = {pref, 3'b000};
    end
    return t;
  endfunction

  // Byte-lane merge of a write, restricted to the kept bits.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_v,
                                                   input logic [WORD_W-1:0] new_v,
                                                   input logic [LANES-1:0]  be,
                                                   input logic [WORD_W-1:0] keep);
    logic [WORD_W-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      if (be[l]) begin
        r[l*8 +: 8] = new_v[l*8 +: 8] & keep[l*8 +: 8];
      end else begin
        r[l*8 +: 8] = old_v[l*8 +: 8];
      end
    end
    return r;
  endfunction

  // Address falls inside the aligned window starting at base.
  function automatic logic window_match(input logic [WORD_W-1:0] addr,
                                        input logic [WORD_W-1:0] base,
                                        input logic [WORD_W-1:0] keep);
    return ((addr ^ base) & keep) == '0;
  endfunction

endpackage

// File: rtl/bar_bank_reg.sv
module bar_bank_reg
  import bar_bank_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 12,
  parameter bit          IS_IO    = 1'b0,
  parameter bit          PREFETCH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] base_q,
  output logic [WORD_W-1:0] rd_word
);

  localparam logic [WORD_W-1:0] KEEP    = keep_mask(WIN_LOG2);
  localparam bit                PRESENT = (KEEP != '0);
  localparam logic [TYPE_W-1:0] TBITS   = type_bits(IS_IO, PREFETCH);

  generate
    if (PRESENT) begin : g_live
      logic [WORD_W-1:0] stored;
      logic [WORD_W-1:0] next_val;

      always_comb next_val = lane_merge(stored, wdata, be, KEEP);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stored <= '0;
        end else if (wr_sel) begin
          stored <= next_val;
        end
      end

      assign base_q  = stored;
      assign rd_word = stored | {{(WORD_W-TYPE_W){1'b0}}, TBITS};

      AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> stored == '0);                              // R1
      AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && be == '1) |=> stored == ($past(wdata) & KEEP));   // R2
      AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !be[1]) |=> stored[15:8] == $past(stored[15:8])); // R2
      AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word & ~KEEP) == {{(WORD_W-TYPE_W){1'b0}}, TBITS});      // R3
    end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{wr_sel, be, wdata, clk, rst_n};
      assign base_q  = '0;
      assign rd_word = '0;
    end
  endgenerate

endmodule

// File: rtl/bar_bank_hit.sv
module bar_bank_hit
  import bar_bank_pkg::*;
#(
  parameter int unsigned NUM_BARS            = 6,
  parameter int unsigned WIN_LOG2 [NUM_BARS] = '{12, 20, 8, 0, 4, 16},
  parameter logic [NUM_BARS-1:0] IO_MASK     = 6'b010100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] base [NUM_BARS],
  input  logic              mem_en,
  input  logic              io_en,
  input  logic [WORD_W-1:0] bus_addr,
  input  logic              bus_is_io,
  output logic [NUM_BARS-1:0] hit
);

  logic mem_cycle_ok;
  logic io_cycle_ok;

  assign mem_cycle_ok = mem_en && !bus_is_io;
  assign io_cycle_ok  = io_en && bus_is_io;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_cmp
    localparam logic [WORD_W-1:0] KEEP = keep_mask(WIN_LOG2[i]);
    logic space_ok;
    logic addr_ok;

    assign space_ok = IO_MASK[i] ? io_cycle_ok : mem_cycle_ok;
    assign addr_ok  = window_match(bus_addr, base[i], KEEP);
    assign hit[i]   = (KEEP != '0) && space_ok && addr_ok;
  end

  AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cycle_ok |-> (hit & ~IO_MASK) == '0);   // R8
  AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !io_cycle_ok |-> (hit & IO_MASK) == '0);     // R9
  AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !((hit & IO_MASK) != '0 && (hit & ~IO_MASK) != '0));  // R9

endmodule

// File: rtl/bar_bank_rd.sv
module bar_bank_rd
  import bar_bank_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6,
  localparam int unsigned IDX_W   = $clog2(NUM_BARS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] words [NUM_BARS],
  output logic [WORD_W-1:0] rdata
);

  logic idx_valid;

  assign idx_valid = int'(idx) < NUM_BARS;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (idx_valid && int'(idx) == i) begin
        rdata = words[i];
      end
    end
  end

  AST_BAD_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_valid |-> rdata == '0);   // R7

endmodule

// File: rtl/bar_bank.sv
module bar_bank
  import bar_bank_pkg::*;
#(
  parameter int unsigned NUM_BARS            = 6,
  parameter int unsigned WIN_LOG2 [NUM_BARS] = '{12, 20, 8, 0, 4, 16},
  parameter logic [NUM_BARS-1:0] IO_MASK     = 6'b010100,
  parameter logic [NUM_BARS-1:0] PREF_MASK   = 6'b000010,
  localparam int unsigned IDX_W              = $clog2(NUM_BARS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [LANES-1:0]    cfg_be,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [WORD_W-1:0]   cfg_rdata,
  input  logic                mem_en,
  input  logic                io_en,
  input  logic [WORD_W-1:0]   bus_addr,
  input  logic                bus_is_io,
  output logic [NUM_BARS-1:0] bar_hit
);

  logic [WORD_W-1:0]   base_q  [NUM_BARS];
  logic [WORD_W-1:0]   rd_word [NUM_BARS];
  logic [NUM_BARS-1:0] wr_sel;
  logic [NUM_BARS-1:0] absent;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    assign wr_sel[i] = cfg_wr && (cfg_idx == IDX_W'(i));
    assign absent[i] = (keep_mask(WIN_LOG2[i]) == '0);

    bar_bank_reg #(
      .WIN_LOG2 (WIN_LOG2[i]),
      .IS_IO    (IO_MASK[i]),
      .PREFETCH (PREF_MASK[i])
    ) i_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wr_sel[i]),
      .be      (cfg_be),
      .wdata   (cfg_wdata),
      .base_q  (base_q[i]),
      .rd_word (rd_word[i])
    );
  end

  bar_bank_rd #(
    .NUM_BARS (NUM_BARS)
  ) i_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (cfg_idx),
    .words (rd_word),
    .rdata (cfg_rdata)
  );

  bar_bank_hit #(
    .NUM_BARS (NUM_BARS),
    .WIN_LOG2 (WIN_LOG2),
    .IO_MASK  (IO_MASK)
  ) i_hit (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (base_q),
    .mem_en    (mem_en),
    .io_en     (io_en),
    .bus_addr  (bus_addr),
    .bus_is_io (bus_is_io),
    .hit       (bar_hit)
  );

  AST_EMPTY_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_hit & absent) == '0);   // R6
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));           // R7

endmodule

// File: tb/test_bar_bank.sv
module test_bar_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_en = 1'b0;
  logic        io_en = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_is_io = 1'b0;
  logic [5:0]  bar_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bar_bank i_bar_bank (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_en(mem_en), .io_en(io_en), .bus_addr(bus_addr),
    .bus_is_io(bus_is_io), .bar_hit(bar_hit)
  );

  typedef struct packed {
    logic [2:0]  idx;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  // Windows: 0 mem 4K, 1 mem 1M prefetchable, 2 io 256, 3 absent, 4 io 16, 5 mem 64K
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_F000, "R3"},
    '{3'd1, 32'hFFFF_FFFF, 4'hF, 32'hFFF0_0008, "R4"},
    '{3'd2, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_FF01, "R5"},
    '{3'd3, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, "R6"},
    '{3'd4, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_FFF1, "R3"},
    '{3'd5, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_0000, "R3"},
    '{3'd0, 32'h1234_5678, 4'hF, 32'h1234_5000, "R2"},
    '{3'd1, 32'hABCD_EF07, 4'hF, 32'hABC0_0008, "R4"},
    '{3'd2, 32'h0000_C3A5, 4'hF, 32'h0000_C301, "R5"},
    '{3'd5, 32'h8001_0000, 4'hF, 32'h8001_0000, "R2"},
    '{3'd0, 32'hFFFF_FFFF, 4'h2, 32'h1234_F000, "R2"},
    '{3'd0, 32'h0000_0000, 4'h8, 32'h0034_F000, "R2"},
    '{3'd6, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, "R7"},
    '{3'd4, 32'h0000_1230, 4'hF, 32'h0000_1231, "R5"}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d,
                           input logic [3:0] be);
    @(negedge clk);
    cfg_idx = idx; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp,
                        input string what);
    cfg_idx = idx;
    #1;
    chk(cfg_rdata, exp, what);
  endtask

  task automatic hit_chk(input logic [31:0] a, input logic io, input logic me,
                         input logic ie, input logic [5:0] exp, input string what);
    bus_addr = a; bus_is_io = io; mem_en = me; io_en = ie;
    #1;
    chk({26'd0, bar_hit}, {26'd0, exp}, what);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, type bits only
    rd_chk(3'd0, 32'h0000_0000, "R1 reset reg0");
    rd_chk(3'd1, 32'h0000_0008, "R1 reset reg1");
    rd_chk(3'd2, 32'h0000_0001, "R1 reset reg2");
    rd_chk(3'd4, 32'h0000_0001, "R1 reset reg4");
    rd_chk(3'd5, 32'h0000_0000, "R1 reset reg5");
    // R6: zero bases decode address 0x10 for mem windows, never for absent reg3
    hit_chk(32'h0000_0010, 1'b0, 1'b1, 1'b0, 6'b100011, "R6 absent no hit after reset");

    for (int v = 0; v < NV; v++) begin
      cfg_write(VECS[v].idx, VECS[v].wd, VECS[v].be);
      rd_chk(VECS[v].idx, VECS[v].exp, $sformatf("%s vector %0d", VECS[v].tag, v));
    end
    // R7: index 6 write left reg5 and reg4 alone
    rd_chk(3'd5, 32'h8001_0000, "R7 reg5 after bad index write");
    rd_chk(3'd7, 32'h0000_0000, "R7 read index 7");

    // Bases: r0 0034F000, r1 ABC00000, r2 0000C300, r4 00001230, r5 80010000
    hit_chk(32'h0034_FABC, 1'b0, 1'b1, 1'b0, 6'b000001, "R8 mem hit reg0");
    hit_chk(32'hABC1_2345, 1'b0, 1'b1, 1'b0, 6'b000010, "R8 mem hit reg1");
    hit_chk(32'h8001_FFFF, 1'b0, 1'b1, 1'b0, 6'b100000, "R8 mem hit reg5 top");
    hit_chk(32'h8002_0000, 1'b0, 1'b1, 1'b0, 6'b000000, "R8 mem miss past reg5");
    hit_chk(32'h0034_FABC, 1'b0, 1'b0, 1'b1, 6'b000000, "R8 mem disabled");
    hit_chk(32'h0000_C3FF, 1'b1, 1'b0, 1'b1, 6'b000100, "R9 io hit reg2");
    hit_chk(32'h0000_123C, 1'b1, 1'b0, 1'b1, 6'b010000, "R9 io hit reg4");
    hit_chk(32'h0000_C3FF, 1'b1, 1'b1, 1'b0, 6'b000000, "R9 io disabled");
    hit_chk(32'h0034_FABC, 1'b1, 1'b1, 1'b1, 6'b000000, "R9 io cycle ignores mem window");
    hit_chk(32'h0000_C3FF, 1'b0, 1'b1, 1'b1, 6'b000000, "R9 mem cycle ignores io window");

    // R10: new base visible only after the rising edge
    @(negedge clk);
    hit_chk(32'h8002_0000, 1'b0, 1'b1, 1'b0, 6'b000000, "R10 before write");
    cfg_idx = 3'd5; cfg_wdata = 32'h8002_0000; cfg_be = 4'hF; cfg_wr = 1'b1;
    #1;
    chk({26'd0, bar_hit}, 32'd0, "R10 write pending, old base");
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    chk({26'd0, bar_hit}, 32'h0000_0020, "R10 new base after edge");

    // R1: reset clears again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(3'd0, 32'h0000_0000, "R1 reg0 after second reset");
    rd_chk(3'd1, 32'h0000_0008, "R1 reg1 after second reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule